// File: doc/BRIEF.md
# Staged Pipeline Control Unit

This block produces the datapath control for a five-stage in-order pipeline. The opcode of the instruction held in the fetch/decode register is decoded combinationally, once, into a full control bundle. The bundle splits into three groups: execute (destination select, ALU mode, immediate operand select), memory (branch, read, write) and writeback (register write enable, writeback source select). Each group is carried forward through the stage registers and presented at the stage that uses it. The bundle shrinks at each stage, because a stage register keeps only the groups that later stages still need.

The fetch/decode register is inside the block and captures the fetched instruction word on every clock unless the stall input is high. A stall holds that register and sends a zero bundle into the execute stage. A flush sends a zero bundle into the execute stage but lets fetch advance. A zero bundle is a bubble: it writes nothing, reads nothing and does not branch.

Top module: `ctl_stage_unit`

## Requirements
- R1: Opcode 000000 (instruction bits [31:26]) decodes to destination select 1, ALU mode 10, immediate select 0, branch 0, memory read 0, memory write 0, register write 1, writeback-from-memory 0.
- R2: Opcode 100011 decodes to destination select 0, ALU mode 00, immediate select 1, branch 0, memory read 1, memory write 0, register write 1, writeback-from-memory 1.
- R3: Opcode 101011 decodes to ALU mode 00, immediate select 1, memory write 1, and to 0 for destination select, branch, memory read, register write and writeback-from-memory. No more than one of the three memory-stage controls is ever high.
- R4: Opcode 000100 decodes to ALU mode 01, branch 1, and to 0 for every other control.
- R5: Every other opcode, and every value of bits [25:0], gives an all-zero bundle.
- R6: An instruction captured at clock edge k shows its execute group after edge k+1, its memory group after edge k+2 and its writeback group after edge k+3. Each stage passes on unchanged the groups it received from the stage before it.
- R7: When stall is high at an edge, the fetch/decode register keeps its instruction and the execute group becomes all zero after that edge. The held instruction is decoded at the next edge without a stall.
- R8: When flush is high at an edge, the execute group becomes all zero after that edge, and the bubble moves on through the memory and writeback stages.
- R9: A synchronous reset clears every stage output to zero. After reset the fetch/decode register holds no instruction, so the execute stage receives zero bundles until an instruction has been captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_instr | input | 32 | Instruction word from the fetch stage |
| stall | input | 1 | Hold fetch/decode and insert a bubble |
| flush | input | 1 | Insert a bubble into the execute stage |
| ex_dst_rd | output | 1 | Execute: destination register from the rd field |
| ex_alu_op | output | 2 | Execute: ALU mode |
| ex_src_imm | output | 1 | Execute: second ALU operand is the immediate |
| mem_branch | output | 1 | Memory: branch on equal |
| mem_rd | output | 1 | Memory: data read |
| mem_wr | output | 1 | Memory: data write |
| wb_reg_we | output | 1 | Writeback: register file write enable |
| wb_sel_mem | output | 1 | Writeback: write data comes from memory |

## Verification
The execute group of an instruction driven before edge k is due two edges later (k+1 after the fetch/decode register), the memory group one edge after that and the writeback group one more edge later. The bench drives inputs on the falling edge. A reference pipeline in the bench is updated on the rising edge with the same stall, flush and reset rules, and every falling edge compares each stage's outputs with the matching stage of that reference. Each comparison is tagged with the requirement of the opcode class or bubble cause it holds. In this way a value that arrives one cycle early or late, or that comes from the wrong stage, fails against the instruction that should be in that stage.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'b00,
        ALU_SUB  = 2'b01,
        ALU_FUNC = 2'b10,
        ALU_RSVD = 2'b11
    } alu_mode_e;

    typedef struct packed {
        logic      dst_rd;
        alu_mode_e alu_op;
        logic      src_imm;
    } ex_ctl_t;

    typedef struct packed {
        logic branch;
        logic rd;
        logic wr;
    } mem_ctl_t;

    typedef struct packed {
        logic reg_we;
        logic sel_mem;
    } wb_ctl_t;

    // Full bundle held in ID/EX
    typedef struct packed {
        ex_ctl_t  ex;
        mem_ctl_t mem;
        wb_ctl_t  wb;
    } ctl_bundle_t;

    // Reduced bundle held in EX/MEM
    typedef struct packed {
        mem_ctl_t mem;
        wb_ctl_t  wb;
    } ctl_late_t;

    function automatic ctl_bundle_t bubble_bundle();
        ctl_bundle_t b;
        b = '0;
        return b;
    endfunction

    function automatic ctl_late_t drop_ex(input ctl_bundle_t b);
        ctl_late_t l;
        l.mem = b.mem;
        l.wb  = b.wb;
        return l;
    endfunction

endpackage

// File: rtl/ctl_fetch_latch.sv
module ctl_fetch_latch #(
    parameter int IW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic [IW-1:0] word_in,
    output logic [IW-1:0] word_q,
    output logic          full_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            full_q <= 1'b0;
        end else if (!hold) begin
            word_q <= word_in;
            full_q <= 1'b1;
        end
    end

endmodule

// File: rtl/ctl_decoder.sv
module ctl_decoder
    import ctl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic             present,
    output ctl_bundle_t      bundle
);

    always_comb begin
        bundle = bubble_bundle();
        if (present) begin
            unique case (opcode)
                OPC_RTYPE: begin
                    bundle.ex.dst_rd  = 1'b1;
                    bundle.ex.alu_op  = ALU_FUNC;
                    bundle.wb.reg_we  = 1'b1;
                end
                OPC_LOAD: begin
                    bundle.ex.alu_op  = ALU_ADD;
                    bundle.ex.src_imm = 1'b1;
                    bundle.mem.rd     = 1'b1;
                    bundle.wb.reg_we  = 1'b1;
                    bundle.wb.sel_mem = 1'b1;
                end
                OPC_STORE: begin
                    bundle.ex.alu_op  = ALU_ADD;
                    bundle.ex.src_imm = 1'b1;
                    bundle.mem.wr     = 1'b1;
                end
                OPC_BEQ: begin
                    bundle.ex.alu_op  = ALU_SUB;
                    bundle.mem.branch = 1'b1;
                end
                default: bundle = bubble_bundle();
            endcase
        end
    end

endmodule

// File: rtl/ctl_stage_reg.sv
module ctl_stage_reg #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bubble,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst || bubble) q <= '0;
        else               q <= d;
    end

endmodule

// File: rtl/ctl_stage_unit.sv
module ctl_stage_unit
    import ctl_pkg::*;
#(
    parameter int IW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] fetch_instr,
    input  logic          stall,
    input  logic          flush,
    output logic          ex_dst_rd,
    output logic [1:0]    ex_alu_op,
    output logic          ex_src_imm,
    output logic          mem_branch,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          wb_reg_we,
    output logic          wb_sel_mem
);

    localparam int OPC_LSB = IW - OPC_W;
    localparam int BUNDLE_W = $bits(ctl_bundle_t);
    localparam int LATE_W   = $bits(ctl_late_t);
    localparam int WB_W     = $bits(wb_ctl_t);

    logic [IW-1:0] ifid_word;
    logic          ifid_full;
    ctl_bundle_t   dec_bundle;
    ctl_bundle_t   idex_q;
    ctl_late_t     exmem_q;
    wb_ctl_t       memwb_q;
    logic          idex_bubble;
    logic          unused_operand_bits;

    assign unused_operand_bits = ^ifid_word[OPC_LSB-1:0];

    // IF/ID
    ctl_fetch_latch #(.IW(IW)) u_ifid (
        .clk     (clk),
        .rst     (rst),
        .hold    (stall),
        .word_in (fetch_instr),
        .word_q  (ifid_word),
        .full_q  (ifid_full)
    );

    // ID: single combinational decode
    ctl_decoder u_dec (
        .opcode  (ifid_word[IW-1:OPC_LSB]),
        .present (ifid_full),
        .bundle  (dec_bundle)
    );

    assign idex_bubble = stall | flush;

    // ID/EX: all three groups
    ctl_stage_reg #(.W(BUNDLE_W)) u_idex (
        .clk    (clk),
        .rst    (rst),
        .bubble (idex_bubble),
        .d      (dec_bundle),
        .q      (idex_q)
    );

    // EX/MEM: memory and writeback groups
    ctl_stage_reg #(.W(LATE_W)) u_exmem (
        .clk    (clk),
        .rst    (rst),
        .bubble (1'b0),
        .d      (drop_ex(idex_q)),
        .q      (exmem_q)
    );

    // MEM/WB: writeback group
    ctl_stage_reg #(.W(WB_W)) u_memwb (
        .clk    (clk),
        .rst    (rst),
        .bubble (1'b0),
        .d      (exmem_q.wb),
        .q      (memwb_q)
    );

    assign ex_dst_rd  = idex_q.ex.dst_rd;
    assign ex_alu_op  = idex_q.ex.alu_op;
    assign ex_src_imm = idex_q.ex.src_imm;
    assign mem_branch = exmem_q.mem.branch;
    assign mem_rd     = exmem_q.mem.rd;
    assign mem_wr     = exmem_q.mem.wr;
    assign wb_reg_we  = memwb_q.reg_we;
    assign wb_sel_mem = memwb_q.sel_mem;

endmodule

module ctl_stage_checker
    import ctl_pkg::*;
#(
    parameter int IW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          stall,
    input logic          flush,
    input logic [IW-1:0] ifid_word,
    input ctl_bundle_t   idex_q,
    input ctl_late_t     exmem_q,
    input logic          ex_dst_rd,
    input logic [1:0]    ex_alu_op,
    input logic          ex_src_imm,
    input logic          mem_branch,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          wb_reg_we,
    input logic          wb_sel_mem
);

    logic rst_seen = 1'b0;

    always_ff @(posedge clk) rst_seen <= rst;

    always @(negedge clk) begin
        if (rst_seen) begin
            // R9
            reset_clear_chk: assert ({ex_dst_rd, ex_alu_op, ex_src_imm, mem_branch,
                                      mem_rd, mem_wr, wb_reg_we, wb_sel_mem} == 8'd0)
                else $error("stage outputs not cleared by reset");
        end
    end

    // R7
    stall_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> ({ex_dst_rd, ex_alu_op, ex_src_imm} == 4'd0));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(ifid_word));

    // R8
    flush_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> ({ex_dst_rd, ex_alu_op, ex_src_imm} == 4'd0));

    // R6
    mem_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ({mem_branch, mem_rd, mem_wr} == $past(idex_q.mem)));

    // R6
    wb_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ({wb_reg_we, wb_sel_mem} == $past(exmem_q.wb)));

    // R3
    mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_branch, mem_rd, mem_wr}));

    // R2
    imm_mode_chk: assert property (@(posedge clk) disable iff (rst)
        ex_src_imm |-> (ex_alu_op == 2'b00));

    // R1
    dst_mode_chk: assert property (@(posedge clk) disable iff (rst)
        ex_dst_rd |-> (ex_alu_op == 2'b10 && !ex_src_imm));

endmodule

bind ctl_stage_unit ctl_stage_checker #(.IW(IW)) u_ctl_chk (
    .clk        (clk),
    .rst        (rst),
    .stall      (stall),
    .flush      (flush),
    .ifid_word  (ifid_word),
    .idex_q     (idex_q),
    .exmem_q    (exmem_q),
    .ex_dst_rd  (ex_dst_rd),
    .ex_alu_op  (ex_alu_op),
    .ex_src_imm (ex_src_imm),
    .mem_branch (mem_branch),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .wb_reg_we  (wb_reg_we),
    .wb_sel_mem (wb_sel_mem)
);

// File: tb/ctl_stage_unit_bench.sv
module ctl_stage_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_instr = 32'd0;
    logic        stall = 1'b0;
    logic        flush = 1'b0;
    logic        ex_dst_rd, ex_src_imm, mem_branch, mem_rd, mem_wr, wb_reg_we, wb_sel_mem;
    logic [1:0]  ex_alu_op;

    int checks = 0;
    int errors = 0;
    bit chk_en = 1'b0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ctl_stage_unit u_ctl_stage_unit (
        .clk(clk), .rst(rst), .fetch_instr(fetch_instr), .stall(stall), .flush(flush),
        .ex_dst_rd(ex_dst_rd), .ex_alu_op(ex_alu_op), .ex_src_imm(ex_src_imm),
        .mem_branch(mem_branch), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .wb_reg_we(wb_reg_we), .wb_sel_mem(wb_sel_mem)
    );

    // Expected bundle from the requirement tables:
    // [8] dst [7:6] alu mode [5] imm [4] branch [3] read [2] write [1] reg we [0] wb from mem
    function automatic logic [8:0] spec_bundle(input logic [5:0] op);
        case (op)
            6'b000000: return 9'b1_10_0_000_10; // R1
            6'b100011: return 9'b0_00_1_010_11; // R2
            6'b101011: return 9'b0_00_1_001_00; // R3
            6'b000100: return 9'b0_01_0_100_00; // R4
            default:   return 9'b0;            // R5
        endcase
    endfunction

    // kind: 0 reset/empty, 1..5 opcode class, 6 stall bubble, 7 flush bubble
    function automatic int spec_kind(input logic [5:0] op);
        case (op)
            6'b000000: return 1;
            6'b100011: return 2;
            6'b101011: return 3;
            6'b000100: return 4;
            default:   return 5;
        endcase
    endfunction

    function automatic string kind_tag(input int k);
        case (k)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R7";
            7: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Reference pipeline
    logic [31:0] m_ifid = '0;
    logic        m_full = 1'b0;
    logic [8:0]  m_idex = '0;
    logic [4:0]  m_exmem = '0;
    logic [1:0]  m_memwb = '0;
    int          k_idex = 0, k_exmem = 0, k_memwb = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_ifid <= '0; m_full <= 1'b0;
            m_idex <= '0; m_exmem <= '0; m_memwb <= '0;
            k_idex <= 0; k_exmem <= 0; k_memwb <= 0;
        end else begin
            if (!stall) begin
                m_ifid <= fetch_instr;
                m_full <= 1'b1;
            end
            if (stall) begin
                m_idex <= '0; k_idex <= 6;
            end else if (flush) begin
                m_idex <= '0; k_idex <= 7;
            end else if (!m_full) begin
                m_idex <= '0; k_idex <= 0;
            end else begin
                m_idex <= spec_bundle(m_ifid[31:26]);
                k_idex <= spec_kind(m_ifid[31:26]);
            end
            m_exmem <= m_idex[4:0];
            k_exmem <= k_idex;
            m_memwb <= m_exmem[1:0];
            k_memwb <= k_exmem;
        end
        chk_en <= 1'b1;
    end

    task automatic check(input string tag, input string what, input logic [4:0] act,
                         input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // R6: stage-aligned comparison on every falling edge
    always @(negedge clk) begin
        if (chk_en && !done) begin
            check(kind_tag(k_idex), "EX group",
                  {1'b0, ex_dst_rd, ex_alu_op, ex_src_imm}, {1'b0, m_idex[8:5]});
            check(kind_tag(k_exmem), "MEM group",
                  {2'b0, mem_branch, mem_rd, mem_wr}, {2'b0, m_exmem[4:2]});
            check(kind_tag(k_memwb), "WB group",
                  {3'b0, wb_reg_we, wb_sel_mem}, {3'b0, m_memwb});
        end
    end

    function automatic logic [5:0] pick_op();
        logic [5:0] legal [4] = '{6'b000000, 6'b100011, 6'b101011, 6'b000100};
        if (($urandom % 10) < 7) return legal[$urandom % 4];
        return 6'($urandom % 64);
    endfunction

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        // R9: reset with activity on the inputs
        repeat (3) begin
            @(negedge clk);
            fetch_instr = {6'b100011, 26'h155};
        end
        @(negedge clk);
        rst = 1'b0;
        // R1..R5: sweep every opcode with varied operand bits
        for (int op = 0; op < 64; op++) begin
            @(negedge clk);
            fetch_instr = {6'(op), 26'($urandom)};
        end
        repeat (4) @(negedge clk);
        // R7, R8: legal-heavy stream with random stalls and flushes
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            fetch_instr = {pick_op(), 26'($urandom)};
            stall = (($urandom % 5) == 0);
            flush = (($urandom % 7) == 0);
        end
        // Back-to-back stalls followed by release: held word must decode
        @(negedge clk);
        fetch_instr = {6'b101011, 26'h0}; stall = 1'b0; flush = 1'b0;
        @(negedge clk);
        fetch_instr = {6'b000000, 26'h1}; stall = 1'b1;
        repeat (2) @(negedge clk);
        stall = 1'b0;
        // R9: reset in mid-stream
        repeat (3) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        fetch_instr = {6'b000100, 26'h3};
        repeat (6) @(negedge clk);
        finish_run();
    end

endmodule